// File: doc/BRIEF.md
# Ethernet PAUSE Flow-Control Engine

This block runs full-duplex MAC flow control. The receive path hands it PAUSE frames that are already parsed, as a one-cycle strobe with a 16-bit operand. The block then holds off the start of the next transmit frame for that many pause quanta. One quantum is 512 bit times, and the bit time follows the link speed. A frame already on the wire is never cut short, because the hold only gates frame starts.

On the local side, the engine compares the receive FIFO fill level against a programmable threshold. It asks the transmit path to send an automatic PAUSE frame carrying a programmable operand. A local timer then tracks how long the link partner was told to wait.

An optional zero-time mode adds two early releases:
- A received PAUSE with operand 0 cancels the local transmit wait.
- If the FIFO drains below the threshold while the advertised time is still running, the engine requests a PAUSE with operand 0 to release the partner.

A separate control bit decides whether each received PAUSE frame is forwarded to the DMA side or dropped.

Top module: `pause_flow_ctrl`

## Requirements
- R1: After reset, txHold, pauseReq, pauseFwd and pauseDrop are all 0, and both control inputs are expected at 0.
- R2: A PAUSE strobe with operand T not equal to 0 raises txHold on the next cycle, and txHold stays high for exactly T times Q clock cycles. Q is the number of cycles per quantum: speedSel 2'b00 selects the 10 Mb/s count, 2'b01 the 100 Mb/s count, and 2'b10 or 2'b11 the 1000 Mb/s count.
- R3: A non-zero PAUSE strobe received while txHold is high reloads the wait. txHold then stays high for exactly T times Q cycles counted from the new strobe.
- R4: With zeroTimeEn at 0, a PAUSE strobe with operand 0 has no effect on txHold, whether a wait is running or not.
- R5: With zeroTimeEn at 1, a PAUSE strobe with operand 0 drops txHold on the next cycle.
- R6: When rxFifoLevel is at or above fifoThresh, no advertised time is running and no request is pending, pauseReq rises on the next cycle with pauseReqTime equal to autoPauseTime. Below the threshold, no non-zero request is made.
- R7: An acknowledged non-zero request starts an advertised timer of autoPauseTime times Q cycles. If the level is still at or above the threshold, the next request appears Q times autoPauseTime plus 1 cycles after the acknowledge.
- R8: With zeroTimeEn at 1, a level below the threshold while the advertised timer runs raises pauseReq with pauseReqTime 0. Its acknowledge ends the advertised time, and no second zero-time request follows in that episode. With zeroTimeEn at 0, no request with operand 0 is ever made.
- R9: One cycle after each PAUSE strobe, pauseFwd pulses if fwdPauseEn is 1 and pauseDrop pulses if it is 0. The two are never high together.
- R10: At most one request is outstanding. pauseReq and pauseReqTime hold steady until pauseAck is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| zeroTimeEn | input | 1 | Enables the zero-operand cancel and release behaviour |
| fwdPauseEn | input | 1 | 1 forwards received PAUSE frames to DMA, 0 drops them |
| speedSel | input | 2 | Link speed: 00 10M, 01 100M, 1x 1000M |
| rxPauseValid | input | 1 | One-cycle strobe for a parsed PAUSE frame |
| rxPauseTime | input | 16 | Quanta operand of the received PAUSE |
| rxFifoLevel | input | LVL_W | Receive FIFO fill level |
| fifoThresh | input | LVL_W | Flow-control threshold |
| autoPauseTime | input | 16 | Operand used for automatic non-zero PAUSE frames |
| pauseAck | input | 1 | Transmit path has taken the pending request |
| txHold | output | 1 | Blocks the start of the next transmit frame |
| pauseReq | output | 1 | Request to send a PAUSE frame |
| pauseReqTime | output | 16 | Operand for the requested PAUSE frame |
| pauseFwd | output | 1 | Pulse: the last received PAUSE goes to DMA |
| pauseDrop | output | 1 | Pulse: the last received PAUSE is dropped |

## Verification
The bench measures hold length to the exact cycle at all three speed codes, including the alias code 2'b11. A quantum prescaler that is off by one, or a wrong speed mapping, therefore shows up as a wrong count. It sends a reload partway through a wait, which catches a design that adds the new operand to the old one or keeps the old prescaler phase. It also sends zero-operand frames in both modes, which catches a design that cancels when it should not, or that makes an idle link start holding. On the request side it holds off the acknowledge, then checks three things:
- the refresh delay after the advertised time expires;
- that a drained FIFO gives exactly one zero-time request only when the mode is on;
- that the released partner can be paused again at once.

// File: rtl/pause_pkg.sv
package pause_pkg;

  // Strobes from the control to the datapath timers.
  typedef struct packed {
    logic loadWait;    // start or reload the local transmit wait
    logic cancelWait;  // zero-operand release of the local wait
    logic loadAdv;     // acknowledged request: (re)load advertised timer
  } dpCtl_t;

  typedef enum logic [1:0] {
    SPD_10M   = 2'b00,
    SPD_100M  = 2'b01,
    SPD_1G    = 2'b10,
    SPD_1GALT = 2'b11
  } speed_e;

endpackage

// File: rtl/pause_qtimer.sv
module pause_qtimer #(
  parameter int QW = 13,
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [QW-1:0] qLimit,
  input  logic          load,
  input  logic [TW-1:0] loadVal,
  output logic          busy
);

  logic [TW-1:0] quanta;
  logic [QW-1:0] pre;
  logic [QW-1:0] lastTick;

  assign lastTick = qLimit - QW'(1);
  assign busy     = (quanta != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      quanta <= '0;
      pre    <= '0;
    end else if (load) begin
      quanta <= loadVal;
      pre    <= '0;
    end else if (quanta != '0) begin
      if (pre >= lastTick) begin
        pre    <= '0;
        quanta <= quanta - TW'(1);
      end else begin
        pre <= pre + QW'(1);
      end
    end
  end

endmodule

// File: rtl/pause_dp.sv
module pause_dp
  import pause_pkg::*;
#(
  parameter int Q_CYC_1G   = 64,
  parameter int Q_CYC_100M = 640,
  parameter int Q_CYC_10M  = 6400,
  parameter int TW         = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [1:0]    speedSel,
  input  dpCtl_t        ctl,
  input  logic [TW-1:0] rxPauseTime,
  input  logic [TW-1:0] advTime,
  output logic          waitBusy,
  output logic          advBusy
);

  localparam int QMAX_A = (Q_CYC_1G > Q_CYC_100M) ? Q_CYC_1G : Q_CYC_100M;
  localparam int QMAX   = (QMAX_A > Q_CYC_10M) ? QMAX_A : Q_CYC_10M;
  localparam int QW     = $clog2(QMAX + 1);
  localparam int NTMR   = 2;  // index 0: local wait, 1: advertised time

  logic [QW-1:0] qLimit;
  logic          tLoad [NTMR];
  logic [TW-1:0] tVal  [NTMR];
  logic          tBusy [NTMR];

  always_comb begin
    case (speed_e'(speedSel))
      SPD_10M:  qLimit = QW'(Q_CYC_10M);
      SPD_100M: qLimit = QW'(Q_CYC_100M);
      default:  qLimit = QW'(Q_CYC_1G);
    endcase
  end

  // Wait timer: a cancel is a load with zero.
  assign tLoad[0] = ctl.loadWait | ctl.cancelWait;
  assign tVal[0]  = ctl.cancelWait ? '0 : rxPauseTime;
  // Advertised timer: an acknowledged zero-time request clears it.
  assign tLoad[1] = ctl.loadAdv;
  assign tVal[1]  = advTime;

  for (genvar i = 0; i < NTMR; i++) begin : g_tmr
    pause_qtimer #(.QW(QW), .TW(TW)) u_tmr (
      .clk     (clk),
      .rstN    (rstN),
      .qLimit  (qLimit),
      .load    (tLoad[i]),
      .loadVal (tVal[i]),
      .busy    (tBusy[i])
    );
  end

  assign waitBusy = tBusy[0];
  assign advBusy  = tBusy[1];

endmodule

// File: rtl/pause_ctrl.sv
module pause_ctrl
  import pause_pkg::*;
#(
  parameter int LVL_W = 10,
  parameter int TW    = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             zeroTimeEn,
  input  logic             fwdPauseEn,
  input  logic             rxPauseValid,
  input  logic [TW-1:0]    rxPauseTime,
  input  logic [LVL_W-1:0] rxFifoLevel,
  input  logic [LVL_W-1:0] fifoThresh,
  input  logic [TW-1:0]    autoPauseTime,
  input  logic             pauseAck,
  input  logic             advBusy,
  output dpCtl_t           ctl,
  output logic             pauseReq,
  output logic [TW-1:0]    pauseReqTime,
  output logic             pauseFwd,
  output logic             pauseDrop
);

  logic rxZero;
  logic aboveThr;
  logic wantZero;
  logic wantAuto;

  assign rxZero   = (rxPauseTime == '0);
  assign aboveThr = (rxFifoLevel >= fifoThresh);
  assign wantZero = zeroTimeEn && advBusy && !aboveThr;
  assign wantAuto = !advBusy && aboveThr && (autoPauseTime != '0);

  always_comb begin
    ctl.loadWait   = rxPauseValid && !rxZero;
    ctl.cancelWait = rxPauseValid && rxZero && zeroTimeEn;
    ctl.loadAdv    = pauseReq && pauseAck;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pauseReq     <= 1'b0;
      pauseReqTime <= '0;
    end else if (pauseReq) begin
      if (pauseAck) pauseReq <= 1'b0;
    end else if (wantZero) begin
      pauseReq     <= 1'b1;
      pauseReqTime <= '0;
    end else if (wantAuto) begin
      pauseReq     <= 1'b1;
      pauseReqTime <= autoPauseTime;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pauseFwd  <= 1'b0;
      pauseDrop <= 1'b0;
    end else begin
      pauseFwd  <= rxPauseValid && fwdPauseEn;
      pauseDrop <= rxPauseValid && !fwdPauseEn;
    end
  end

endmodule

// File: rtl/pause_flow_ctrl.sv
module pause_flow_ctrl
  import pause_pkg::*;
#(
  parameter int LVL_W      = 10,
  parameter int Q_CYC_1G   = 64,
  parameter int Q_CYC_100M = 640,
  parameter int Q_CYC_10M  = 6400
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             zeroTimeEn,
  input  logic             fwdPauseEn,
  input  logic [1:0]       speedSel,
  input  logic             rxPauseValid,
  input  logic [15:0]      rxPauseTime,
  input  logic [LVL_W-1:0] rxFifoLevel,
  input  logic [LVL_W-1:0] fifoThresh,
  input  logic [15:0]      autoPauseTime,
  input  logic             pauseAck,
  output logic             txHold,
  output logic             pauseReq,
  output logic [15:0]      pauseReqTime,
  output logic             pauseFwd,
  output logic             pauseDrop
);

  localparam int TW = 16;

  dpCtl_t ctl;
  logic   waitBusy;
  logic   advBusy;

  pause_ctrl #(.LVL_W(LVL_W), .TW(TW)) u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .zeroTimeEn    (zeroTimeEn),
    .fwdPauseEn    (fwdPauseEn),
    .rxPauseValid  (rxPauseValid),
    .rxPauseTime   (rxPauseTime),
    .rxFifoLevel   (rxFifoLevel),
    .fifoThresh    (fifoThresh),
    .autoPauseTime (autoPauseTime),
    .pauseAck      (pauseAck),
    .advBusy       (advBusy),
    .ctl           (ctl),
    .pauseReq      (pauseReq),
    .pauseReqTime  (pauseReqTime),
    .pauseFwd      (pauseFwd),
    .pauseDrop     (pauseDrop)
  );

  pause_dp #(
    .Q_CYC_1G   (Q_CYC_1G),
    .Q_CYC_100M (Q_CYC_100M),
    .Q_CYC_10M  (Q_CYC_10M),
    .TW         (TW)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .speedSel    (speedSel),
    .ctl         (ctl),
    .rxPauseTime (rxPauseTime),
    .advTime     (pauseReqTime),
    .waitBusy    (waitBusy),
    .advBusy     (advBusy)
  );

  assign txHold = waitBusy;

endmodule

// File: rtl/pause_chk.sv
module pause_chk (
  input logic        clk,
  input logic        rstN,
  input logic        zeroTimeEn,
  input logic        fwdPauseEn,
  input logic        rxPauseValid,
  input logic [15:0] rxPauseTime,
  input logic        pauseAck,
  input logic        txHold,
  input logic        pauseReq,
  input logic [15:0] pauseReqTime,
  input logic        pauseFwd,
  input logic        pauseDrop
);

  p_hold_on_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    (rxPauseValid && rxPauseTime != 16'd0) |=> txHold);

  p_zero_ignored_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!zeroTimeEn && !txHold && rxPauseValid && rxPauseTime == 16'd0) |=> !txHold);

  p_zero_cancel_r5: assert property (@(posedge clk) disable iff (!rstN)
    (zeroTimeEn && rxPauseValid && rxPauseTime == 16'd0) |=> !txHold);

  p_zero_req_needs_mode_r8: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(pauseReq) && pauseReqTime == 16'd0) |-> $past(zeroTimeEn));

  p_fwd_select_r9: assert property (@(posedge clk) disable iff (!rstN)
    rxPauseValid |=> (pauseFwd == $past(fwdPauseEn)) && (pauseDrop == !$past(fwdPauseEn)));

  p_fwd_excl_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(pauseFwd && pauseDrop));

  p_req_held_r10: assert property (@(posedge clk) disable iff (!rstN)
    (pauseReq && !pauseAck) |=> (pauseReq && $stable(pauseReqTime)));

endmodule

bind pause_flow_ctrl pause_chk u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .zeroTimeEn   (zeroTimeEn),
  .fwdPauseEn   (fwdPauseEn),
  .rxPauseValid (rxPauseValid),
  .rxPauseTime  (rxPauseTime),
  .pauseAck     (pauseAck),
  .txHold       (txHold),
  .pauseReq     (pauseReq),
  .pauseReqTime (pauseReqTime),
  .pauseFwd     (pauseFwd),
  .pauseDrop    (pauseDrop)
);

// File: tb/tb_pause_flow_ctrl.sv
`timescale 1ns/1ps
module tb_pause_flow_ctrl;

  localparam int LVL_W = 10;
  localparam int Q1G   = 4;
  localparam int Q100  = 6;
  localparam int Q10   = 10;
  localparam int WDOG  = 20000;

  // Table: speed code, forward enable, operand, expected hold cycles (T*Q)
  localparam int VEC_N = 6;
  localparam logic [1:0]  V_SPD [VEC_N] = '{2'b10, 2'b11, 2'b01, 2'b00, 2'b10, 2'b00};
  localparam logic        V_FWD [VEC_N] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1};
  localparam logic [15:0] V_T   [VEC_N] = '{16'd3, 16'd1, 16'd4, 16'd2, 16'd7, 16'd1};
  localparam int          V_EXP [VEC_N] = '{12, 4, 24, 20, 28, 10};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic zeroTimeEn = 1'b0, fwdPauseEn = 1'b0;
  logic [1:0] speedSel = 2'b10;
  logic rxPauseValid = 1'b0;
  logic [15:0] rxPauseTime = '0;
  logic [LVL_W-1:0] rxFifoLevel = '0, fifoThresh = 10'd100;
  logic [15:0] autoPauseTime = 16'd3;
  logic pauseAck = 1'b0;
  logic txHold, pauseReq, pauseFwd, pauseDrop;
  logic [15:0] pauseReqTime;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pause_flow_ctrl #(.LVL_W(LVL_W), .Q_CYC_1G(Q1G), .Q_CYC_100M(Q100), .Q_CYC_10M(Q10)) dut (
    .clk(clk), .rstN(rstN), .zeroTimeEn(zeroTimeEn), .fwdPauseEn(fwdPauseEn),
    .speedSel(speedSel), .rxPauseValid(rxPauseValid), .rxPauseTime(rxPauseTime),
    .rxFifoLevel(rxFifoLevel), .fifoThresh(fifoThresh), .autoPauseTime(autoPauseTime),
    .pauseAck(pauseAck), .txHold(txHold), .pauseReq(pauseReq),
    .pauseReqTime(pauseReqTime), .pauseFwd(pauseFwd), .pauseDrop(pauseDrop));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Called at a negedge; returns at the negedge after the strobe was sampled.
  task automatic strobe(input logic [15:0] t);
    rxPauseValid = 1'b1;
    rxPauseTime  = t;
    @(negedge clk);
    rxPauseValid = 1'b0;
  endtask

  task automatic waitHoldLow();
    int g = 0;
    while (txHold && g < 5000) begin
      @(negedge clk);
      g++;
    end
  endtask

  task automatic ackOnce();
    pauseAck = 1'b1;
    @(negedge clk);
    pauseAck = 1'b0;
  endtask

  always @(posedge clk) begin
    if (cyc > WDOG && !done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected <%0d cycles", cyc, WDOG);
      finishRun();
    end
  end

  initial begin
    int t0;
    int rises;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 txHold", txHold, 0);
    check("R1 pauseReq", pauseReq, 0);
    check("R1 fwd/drop", {pauseFwd, pauseDrop}, 0);
    rstN = 1'b1;
    @(negedge clk);

    // Table walk: R2 hold length per speed code, R9 forward/drop flag
    for (int i = 0; i < VEC_N; i++) begin
      speedSel   = V_SPD[i];
      fwdPauseEn = V_FWD[i];
      strobe(V_T[i]);
      t0 = cyc;
      check("R9 pauseFwd", pauseFwd, int'(V_FWD[i]));
      check("R9 pauseDrop", pauseDrop, int'(!V_FWD[i]));
      waitHoldLow();
      check("R2 hold cycles", cyc - t0, V_EXP[i]);
      @(negedge clk);
      check("R9 pulse one cycle", {pauseFwd, pauseDrop}, 0);
    end

    speedSel = 2'b10;
    // R3 reload during a wait
    strobe(16'd5);
    repeat (3) @(negedge clk);
    strobe(16'd2);
    t0 = cyc;
    waitHoldLow();
    check("R3 reload hold", cyc - t0, 2 * Q1G);

    // R4 zero operand ignored with mode off, while busy and while idle
    zeroTimeEn = 1'b0;
    strobe(16'd3);
    t0 = cyc;
    repeat (2) @(negedge clk);
    strobe(16'd0);
    check("R4 hold kept", txHold, 1);
    waitHoldLow();
    check("R4 hold length", cyc - t0, 3 * Q1G);
    strobe(16'd0);
    check("R4 idle no hold", txHold, 0);

    // R5 zero operand cancels with mode on
    zeroTimeEn = 1'b1;
    strobe(16'd20);
    repeat (3) @(negedge clk);
    check("R5 holding", txHold, 1);
    strobe(16'd0);
    check("R5 cancel", txHold, 0);

    // R6 / R10 / R7 with mode off (R8 off case)
    zeroTimeEn  = 1'b0;
    rxFifoLevel = 10'd50;
    repeat (3) @(negedge clk);
    check("R6 below thresh", pauseReq, 0);
    rxFifoLevel = 10'd100;
    @(negedge clk);
    check("R6 req at thresh", pauseReq, 1);
    check("R6 req time", pauseReqTime, 3);
    repeat (4) @(negedge clk);
    check("R10 req held", pauseReq, 1);
    check("R10 time held", pauseReqTime, 3);
    ackOnce();
    check("R10 req cleared by ack", pauseReq, 0);
    t0 = cyc;
    begin
      int g = 0;
      while (!pauseReq && g < 200) begin
        @(negedge clk);
        g++;
      end
    end
    check("R7 refresh delay", cyc - t0, 3 * Q1G + 1);
    ackOnce();
    rxFifoLevel = 10'd10;
    rises = 0;
    repeat (3 * Q1G + 4) begin
      @(negedge clk);
      if (pauseReq) rises++;
    end
    check("R8 no zero req mode off", rises, 0);

    // R8 zero-time release of the partner
    zeroTimeEn  = 1'b1;
    rxFifoLevel = 10'd120;
    @(negedge clk);
    check("R6 req above thresh", pauseReq, 1);
    ackOnce();
    repeat (2) @(negedge clk);
    check("R8 no zero req while above", pauseReq, 0);
    rxFifoLevel = 10'd10;
    @(negedge clk);
    check("R8 zero req", pauseReq, 1);
    check("R8 zero req time", pauseReqTime, 0);
    ackOnce();
    rises = 0;
    repeat (3 * Q1G + 4) begin
      @(negedge clk);
      if (pauseReq) rises++;
    end
    check("R8 no duplicate", rises, 0);
    rxFifoLevel = 10'd120;
    @(negedge clk);
    check("R8 partner released", pauseReq, 1);
    check("R8 new req time", pauseReqTime, 3);
    ackOnce();

    done = 1'b1;
    finishRun();
  end

endmodule